// File: doc/BRIEF.md
# Temporal Firewall State Buffer

This block holds a small set of state messages between a time-triggered communication controller and a host processor. Data moves one way only. The communication side is the only writer. It writes into an entry, word by word, and then publishes the entry with a single commit. The host is the only reader. It may fetch any word of any entry at any time, and fetching never removes or alters what is stored. Nothing is signalled toward the host: there is no interrupt, no request and no acknowledge. The host learns whether a value is usable by looking at its freshness.

Every entry carries the observation timestamp supplied with its commit. The timestamp is 64 bits wide: the upper 40 bits are whole seconds and the lower 24 bits are a binary fraction. The block compares that timestamp against the running global time and reports whether the entry is still within its accuracy interval. Each entry has its own interval, fixed at elaboration.

Global time also fixes when the writer may touch each entry. The slot field `gtime_i[SLOT_LSB+IDX_W-1:SLOT_LSB]` names the entry whose write window is open. A writer access that falls outside its entry's window is dropped and recorded. A host read that falls inside the window of the entry it reads is recorded as a conflict, and the read still returns the last published contents.

Top module: `tfw_state_buffer`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first access, `rd_data_o`, `rd_stamp_o`, `rd_fresh_o`, `fresh_o`, `conflict_o` and `sched_err_o` are all zero.
- R2: A commit replaces the published words and timestamp of an entry in place, with no history kept. A read request with `rd_en_i` high returns the word selected by `rd_entry_i`/`rd_word_i` on `rd_data_o`, and the entry's timestamp on `rd_stamp_o`, in the cycle after the request.
- R3: Reads are non-consuming. Repeated reads of a word return the same value until the next accepted commit of that entry. The read outputs hold their value in any cycle with `rd_en_i` low.
- R4: Words written with `wr_en_i` are not visible to reads until an accepted `wr_commit_i` for that entry. At the commit, all staged words become visible together. A read in the same cycle as the commit returns the contents from before the commit.
- R5: A write or commit to entry e is accepted only while `gtime_i[SLOT_LSB+IDX_W-1:SLOT_LSB]` equals e (with the defaults, `gtime_i[9:8]`). Any other write or commit changes no stored state and sets the sticky flag `sched_err_o` from the next cycle until reset.
- R6: Entry e is fresh when it has been committed at least once and `(gtime_i - stamp)` modulo 2^64 is at most its interval. The default intervals are 1000, 2000, 3000 and 4000 ticks for entries 0 to 3. An age equal to the interval is fresh. An age one tick larger is stale, and so is a stamp later than the current time. `fresh_o[e]` follows this rule combinationally. `rd_fresh_o` carries the value for the read entry at the time of the request.
- R7: The timestamp is stored and returned bit for bit: 40 bits of seconds in [63:24] and 24 bits of fraction in [23:0].
- R8: A host read of entry e while e's write window is open sets `conflict_o[e]`, which stays set until reset. That read still returns the contents published before it.
- R9: Words that were not rewritten in a window keep their previously staged value when the entry is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gtime_i | input | 64 | Global time, 40.24 fixed point |
| wr_en_i | input | 1 | Stage one word into the writer's entry |
| wr_entry_i | input | IDX_W (2) | Entry addressed by the writer |
| wr_word_i | input | WSEL_W (1) | Word within the entry |
| wr_data_i | input | WORD_W (32) | Word to stage |
| wr_commit_i | input | 1 | Publish the staged words and the timestamp |
| wr_stamp_i | input | 64 | Observation timestamp stored by the commit |
| rd_en_i | input | 1 | Host read request |
| rd_entry_i | input | IDX_W (2) | Entry to read |
| rd_word_i | input | WSEL_W (1) | Word to read |
| rd_data_o | output | WORD_W (32) | Read word, one cycle after the request |
| rd_stamp_o | output | 64 | Timestamp of the read entry |
| rd_fresh_o | output | 1 | Freshness of the read entry at the time of the request |
| fresh_o | output | N_ENTRIES (4) | Current freshness of every entry |
| conflict_o | output | N_ENTRIES (4) | Sticky flags for host reads made inside a write window |
| sched_err_o | output | 1 | Sticky flag for writer accesses made outside their window |

## Verification
Directed sequences cover the following cases:
- A read made before a commit tells staging apart from publishing.
- A commit and a read in the same cycle show that the update is atomic.
- A window in which only one word is rewritten shows what happens to the other words.
- Ages equal to the interval and one tick past it, and a stamp dated in the future, place the freshness threshold exactly.

Writes and commits placed in the wrong slot separate acceptance from rejection. A seeded random mix of in-window and out-of-window writes, commits and reads, spread over shifting times, then checks each returned word, timestamp and freshness flag, and the two sticky flags, against a model of the bench's own.

// File: rtl/tfw_pkg.sv
package tfw_pkg;
  localparam int unsigned TS_W      = 64;
  localparam int unsigned TS_SEC_W  = 40;
  localparam int unsigned TS_FRAC_W = 24;
  typedef logic [TS_W-1:0] tstamp_t;  // [63:24] seconds, [23:0] fraction
endpackage

// File: rtl/tfw_window.sv
module tfw_window #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [IDX_W-1:0]     slot_i,
  output logic [N_ENTRIES-1:0] win_o
);
  // one-hot open window; slot codes >= N_ENTRIES open nothing
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_win
    assign win_o[e] = (slot_i == IDX_W'(e));
  end
endmodule

// File: rtl/tfw_entry.sv
module tfw_entry
  import tfw_pkg::*;
#(
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned WSEL_W  = 1,
  parameter tstamp_t     ACC     = 64'd1000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  tstamp_t                         gtime_i,
  input  logic                            stage_i,
  input  logic [WSEL_W-1:0]               word_i,
  input  logic [WORD_W-1:0]               data_i,
  input  logic                            commit_i,
  input  tstamp_t                         stamp_i,
  output logic [N_WORDS-1:0][WORD_W-1:0]  vis_o,
  output tstamp_t                         stamp_o,
  output logic                            fresh_o
);
  logic [N_WORDS-1:0][WORD_W-1:0] shadow_q, shadow_d, vis_q;
  tstamp_t stamp_q;
  logic    written_q;
  tstamp_t age;

  // staged word merged so a write and a commit in one cycle publish together
  always_comb begin
    shadow_d = shadow_q;
    if (stage_i) shadow_d[word_i] = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      vis_q     <= '0;
      stamp_q   <= '0;
      written_q <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      if (commit_i) begin
        vis_q     <= shadow_d;
        stamp_q   <= stamp_i;
        written_q <= 1'b1;
      end
    end
  end

  assign age     = gtime_i - stamp_q;  // modulo 2^64: future stamps look very old
  assign fresh_o = written_q && (age <= ACC);
  assign vis_o   = vis_q;
  assign stamp_o = stamp_q;
endmodule

// File: rtl/tfw_read_port.sv
module tfw_read_port
  import tfw_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned N_WORDS   = 2,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned WSEL_W    = 1
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           rd_en_i,
  input  logic [IDX_W-1:0]                               rd_entry_i,
  input  logic [WSEL_W-1:0]                              rd_word_i,
  input  logic [N_ENTRIES-1:0][N_WORDS-1:0][WORD_W-1:0]  vis_i,
  input  tstamp_t [N_ENTRIES-1:0]                        stamp_i,
  input  logic [N_ENTRIES-1:0]                           fresh_i,
  output logic [WORD_W-1:0]                              rd_data_o,
  output tstamp_t                                        rd_stamp_o,
  output logic                                           rd_fresh_o
);
  logic        in_range;
  logic [WORD_W-1:0] sel_data;
  tstamp_t     sel_stamp;
  logic        sel_fresh;

  assign in_range = (int'(rd_entry_i) < N_ENTRIES) && (int'(rd_word_i) < N_WORDS);

  always_comb begin
    sel_data  = '0;
    sel_stamp = '0;
    sel_fresh = 1'b0;
    if (in_range) begin
      sel_data  = vis_i[rd_entry_i][rd_word_i];
      sel_stamp = stamp_i[rd_entry_i];
      sel_fresh = fresh_i[rd_entry_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_stamp_o <= '0;
      rd_fresh_o <= 1'b0;
    end else if (rd_en_i) begin
      rd_data_o  <= sel_data;
      rd_stamp_o <= sel_stamp;
      rd_fresh_o <= sel_fresh;
    end
  end
endmodule

// File: rtl/tfw_state_buffer.sv
module tfw_state_buffer
  import tfw_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned N_WORDS   = 2,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned SLOT_LSB  = 8,
  parameter logic [N_ENTRIES*TS_W-1:0] ACC_TICKS =
    {64'd4000, 64'd3000, 64'd2000, 64'd1000},
  localparam int unsigned IDX_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int unsigned WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [TS_W-1:0]       gtime_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_entry_i,
  input  logic [WSEL_W-1:0]     wr_word_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  logic                  wr_commit_i,
  input  logic [TS_W-1:0]       wr_stamp_i,
  input  logic                  rd_en_i,
  input  logic [IDX_W-1:0]      rd_entry_i,
  input  logic [WSEL_W-1:0]     rd_word_i,
  output logic [WORD_W-1:0]     rd_data_o,
  output logic [TS_W-1:0]       rd_stamp_o,
  output logic                  rd_fresh_o,
  output logic [N_ENTRIES-1:0]  fresh_o,
  output logic [N_ENTRIES-1:0]  conflict_o,
  output logic                  sched_err_o
);
  logic [N_ENTRIES-1:0] win;
  logic wr_ent_ok, wr_word_ok, rd_ent_ok, win_hit;
  logic stage_ok, commit_ok, bad_acc;
  logic [N_ENTRIES-1:0][N_WORDS-1:0][WORD_W-1:0] vis;
  tstamp_t [N_ENTRIES-1:0] stamps;
  logic [N_ENTRIES-1:0] conflict_q;
  logic sched_err_q;

  tfw_window #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_window (
    .slot_i (gtime_i[SLOT_LSB +: IDX_W]),
    .win_o  (win)
  );

  assign wr_ent_ok  = int'(wr_entry_i) < N_ENTRIES;
  assign wr_word_ok = int'(wr_word_i) < N_WORDS;
  assign rd_ent_ok  = int'(rd_entry_i) < N_ENTRIES;
  assign win_hit    = wr_ent_ok && win[wr_entry_i];
  assign stage_ok   = wr_en_i && win_hit && wr_word_ok;
  assign commit_ok  = wr_commit_i && win_hit;
  assign bad_acc    = (wr_en_i && !(win_hit && wr_word_ok)) || (wr_commit_i && !win_hit);

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    tfw_entry #(
      .N_WORDS (N_WORDS),
      .WORD_W  (WORD_W),
      .WSEL_W  (WSEL_W),
      .ACC     (ACC_TICKS[e*TS_W +: TS_W])
    ) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .gtime_i  (gtime_i),
      .stage_i  (stage_ok && (wr_entry_i == IDX_W'(e))),
      .word_i   (wr_word_i),
      .data_i   (wr_data_i),
      .commit_i (commit_ok && (wr_entry_i == IDX_W'(e))),
      .stamp_i  (wr_stamp_i),
      .vis_o    (vis[e]),
      .stamp_o  (stamps[e]),
      .fresh_o  (fresh_o[e])
    );
  end

  tfw_read_port #(
    .N_ENTRIES (N_ENTRIES),
    .N_WORDS   (N_WORDS),
    .WORD_W    (WORD_W),
    .IDX_W     (IDX_W),
    .WSEL_W    (WSEL_W)
  ) u_read (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_entry_i (rd_entry_i),
    .rd_word_i  (rd_word_i),
    .vis_i      (vis),
    .stamp_i    (stamps),
    .fresh_i    (fresh_o),
    .rd_data_o  (rd_data_o),
    .rd_stamp_o (rd_stamp_o),
    .rd_fresh_o (rd_fresh_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conflict_q  <= '0;
      sched_err_q <= 1'b0;
    end else begin
      if (bad_acc) sched_err_q <= 1'b1;
      if (rd_en_i && rd_ent_ok && win[rd_entry_i]) conflict_q[rd_entry_i] <= 1'b1;
    end
  end

  assign conflict_o  = conflict_q;
  assign sched_err_o = sched_err_q;
endmodule

// File: rtl/tfw_state_buffer_chk.sv
module tfw_state_buffer_chk #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned N_WORDS   = 2,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned WSEL_W    = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [IDX_W-1:0]     slot_i,
  input logic                 wr_en_i,
  input logic [IDX_W-1:0]     wr_entry_i,
  input logic [WSEL_W-1:0]    wr_word_i,
  input logic                 wr_commit_i,
  input logic                 rd_en_i,
  input logic [WORD_W-1:0]    rd_data_o,
  input logic [63:0]          rd_stamp_o,
  input logic [N_ENTRIES-1:0] fresh_o,
  input logic [N_ENTRIES-1:0] conflict_o,
  input logic                 sched_err_o
);
  logic off_slot, bad_req;
  logic [N_ENTRIES-1:0] seen_q;

  assign off_slot = (int'(wr_entry_i) >= N_ENTRIES) || (slot_i != wr_entry_i);
  assign bad_req  = (wr_commit_i && off_slot) ||
                    (wr_en_i && (off_slot || int'(wr_word_i) >= N_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (wr_commit_i && !off_slot) seen_q[wr_entry_i] <= 1'b1;
  end

  assert_sched_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_err_o |=> sched_err_o);

  assert_sched_err_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sched_err_o) |-> $past(bad_req));

  assert_conflict_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((conflict_o & $past(conflict_o)) == $past(conflict_o)));

  assert_read_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> ($stable(rd_data_o) && $stable(rd_stamp_o)));

  assert_fresh_needs_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fresh_o & ~seen_q) == '0));
endmodule

bind tfw_state_buffer tfw_state_buffer_chk #(
  .N_ENTRIES (N_ENTRIES),
  .N_WORDS   (N_WORDS),
  .WORD_W    (WORD_W),
  .IDX_W     (IDX_W),
  .WSEL_W    (WSEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_i      (gtime_i[SLOT_LSB +: IDX_W]),
  .wr_en_i     (wr_en_i),
  .wr_entry_i  (wr_entry_i),
  .wr_word_i   (wr_word_i),
  .wr_commit_i (wr_commit_i),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .rd_stamp_o  (rd_stamp_o),
  .fresh_o     (fresh_o),
  .conflict_o  (conflict_o),
  .sched_err_o (sched_err_o)
);

// File: tb/tfw_state_buffer_test.sv
module tfw_state_buffer_test;
  localparam int NE = 4;
  localparam int NW = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [63:0] gtime_i;
  logic        wr_en_i, wr_commit_i, rd_en_i;
  logic [1:0]  wr_entry_i, rd_entry_i;
  logic [0:0]  wr_word_i, rd_word_i;
  logic [31:0] wr_data_i;
  logic [63:0] wr_stamp_i;
  logic [31:0] rd_data_o;
  logic [63:0] rd_stamp_o;
  logic        rd_fresh_o;
  logic [3:0]  fresh_o, conflict_o;
  logic        sched_err_o;

  always #4 clk_i = ~clk_i;

  tfw_state_buffer uut (
    .clk_i, .rst_ni, .gtime_i, .wr_en_i, .wr_entry_i, .wr_word_i, .wr_data_i,
    .wr_commit_i, .wr_stamp_i, .rd_en_i, .rd_entry_i, .rd_word_i,
    .rd_data_o, .rd_stamp_o, .rd_fresh_o, .fresh_o, .conflict_o, .sched_err_o
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_vis [NE][NW];
  logic [31:0] m_sh  [NE][NW];
  logic [63:0] m_st  [NE];
  bit          m_wr  [NE];
  bit          m_conf[NE];
  bit          m_err;

  function automatic logic [63:0] acc_of(int e);
    return 64'((e + 1) * 1000);
  endfunction

  function automatic bit slot_is(logic [63:0] t, int e);
    return int'(t[9:8]) == e;
  endfunction

  function automatic bit fresh_exp(int e, logic [63:0] t);
    logic [63:0] age;
    age = t - m_st[e];
    return m_wr[e] && (age <= acc_of(e));
  endfunction

  function automatic logic [63:0] in_win(int e, logic [63:0] base);
    return {base[63:10], 2'(e), base[7:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(string req, logic [63:0] t);
    logic [3:0] ef, ec;
    for (int e = 0; e < NE; e++) begin
      ef[e] = fresh_exp(e, t);
      ec[e] = m_conf[e];
    end
    chk(fresh_o == ef, req, "fresh_o", 64'(fresh_o), 64'(ef));
    chk(conflict_o == ec, "R8", "conflict_o", 64'(conflict_o), 64'(ec));
    chk(sched_err_o == m_err, "R5", "sched_err_o", 64'(sched_err_o), 64'(m_err));
  endtask

  task automatic do_write(int e, int w, logic [31:0] d, logic [63:0] t);
    gtime_i = t; wr_en_i = 1'b1; wr_entry_i = 2'(e); wr_word_i = 1'(w); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (slot_is(t, e)) m_sh[e][w] = d;
    else m_err = 1'b1;
  endtask

  task automatic commit_model(int e, logic [63:0] st, logic [63:0] t);
    if (slot_is(t, e)) begin
      for (int w = 0; w < NW; w++) m_vis[e][w] = m_sh[e][w];
      m_st[e] = st;
      m_wr[e] = 1'b1;
    end else m_err = 1'b1;
  endtask

  task automatic do_commit(int e, logic [63:0] st, logic [63:0] t);
    gtime_i = t; wr_commit_i = 1'b1; wr_entry_i = 2'(e); wr_stamp_i = st;
    @(negedge clk_i);
    wr_commit_i = 1'b0;
    commit_model(e, st, t);
  endtask

  // read, optionally with a commit of entry ce in the same cycle
  task automatic do_read_x(int e, int w, logic [63:0] t, string req, bit with_c, int ce,
                           logic [63:0] st);
    logic [31:0] ed;
    logic [63:0] es;
    bit ef;
    ed = m_vis[e][w]; es = m_st[e]; ef = fresh_exp(e, t);
    gtime_i = t; rd_en_i = 1'b1; rd_entry_i = 2'(e); rd_word_i = 1'(w);
    if (with_c) begin
      wr_commit_i = 1'b1; wr_entry_i = 2'(ce); wr_stamp_i = st;
    end
    if (slot_is(t, e)) m_conf[e] = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_commit_i = 1'b0;
    if (with_c) commit_model(ce, st, t);
    chk(rd_data_o == ed, req, "rd_data_o", 64'(rd_data_o), 64'(ed));
    chk(rd_stamp_o == es, "R7", "rd_stamp_o", rd_stamp_o, es);
    chk(rd_fresh_o == ef, "R6", "rd_fresh_o", 64'(rd_fresh_o), 64'(ef));
    check_flags("R6", t);
  endtask

  task automatic do_read(int e, int w, logic [63:0] t, string req);
    do_read_x(e, w, t, req, 1'b0, 0, 64'd0);
  endtask

  localparam logic [63:0] T0 = 64'h0000_0100_0000_0000;

  initial begin
    logic [63:0] t, s, st7;
    for (int e = 0; e < NE; e++) begin
      for (int w = 0; w < NW; w++) begin m_vis[e][w] = '0; m_sh[e][w] = '0; end
      m_st[e] = '0; m_wr[e] = 0; m_conf[e] = 0;
    end
    m_err = 0;
    rst_ni = 1'b0; gtime_i = T0; wr_en_i = 0; wr_commit_i = 0; rd_en_i = 0;
    wr_entry_i = 0; rd_entry_i = 0; wr_word_i = 0; rd_word_i = 0; wr_data_i = 0; wr_stamp_i = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk(rd_data_o == 0 && rd_stamp_o == 0 && rd_fresh_o == 0, "R1", "read outputs in reset",
        64'(rd_data_o), 64'd0);
    chk(fresh_o == 0 && conflict_o == 0 && sched_err_o == 0, "R1", "flags in reset",
        64'({fresh_o, conflict_o, sched_err_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(fresh_o == 0 && sched_err_o == 0, "R1", "flags after reset", 64'(fresh_o), 64'd0);

    // R4 staging is invisible until commit; R2 commit replaces
    t = in_win(0, T0);
    do_write(0, 0, 32'hA0A0_0001, t);
    do_write(0, 1, 32'hB0B0_0002, t + 1);
    do_read(0, 0, in_win(2, T0), "R4");
    do_commit(0, t + 2, t + 2);
    do_read(0, 0, in_win(2, T0), "R2");
    do_read(0, 1, in_win(2, T0), "R2");
    // R3 repeated reads return the same value
    for (int k = 0; k < 3; k++) do_read(0, 1, in_win(3, T0) + 64'(k), "R3");

    // R9 partial rewrite keeps the other word
    t = in_win(0, T0 + 64'd1024);
    do_write(0, 1, 32'hC0C0_0003, t);
    do_commit(0, t, t + 1);
    do_read(0, 0, in_win(1, T0 + 64'd1024), "R9");
    do_read(0, 1, in_win(1, T0 + 64'd1024), "R2");

    // R4 commit and read in the same cycle: old data; R8 conflict
    t = in_win(1, T0 + 64'd2048);
    do_write(1, 0, 32'hD0D0_0004, t);
    do_read_x(1, 0, t + 1, "R4", 1'b1, 1, t + 1);
    do_read(1, 0, in_win(3, T0 + 64'd2048), "R4");

    // R6 boundaries on entry 2 (interval 3000)
    s = in_win(2, T0 + 64'd4096);
    do_write(2, 0, 32'hE0E0_0005, s);
    do_commit(2, s, s + 1);
    do_read(2, 0, s + 64'd3000, "R6");
    do_read(2, 0, s + 64'd3001, "R6");
    do_read(2, 0, s - 64'd1, "R6");

    // R7 stamp carried bit for bit
    st7 = {40'h12_3456_789A, 24'hBCDEF0};
    t = in_win(3, T0 + 64'd8192);
    do_commit(3, st7, t);
    do_read(3, 0, in_win(0, T0 + 64'd8192), "R7");

    // R5 out-of-window accesses are ignored and flagged
    t = in_win(1, T0 + 64'd12288);
    do_write(0, 0, 32'hBAD0_0BAD, t);
    do_commit(0, t, t + 1);
    do_read(0, 0, in_win(2, T0 + 64'd12288), "R5");
    do_commit(3, 64'd5, in_win(0, T0 + 64'd12288));
    do_read(3, 0, in_win(1, T0 + 64'd12288), "R5");

    // random mix
    void'($urandom(32'd20240611));
    t = T0 + 64'd20000;
    for (int i = 0; i < 400; i++) begin
      int e, w, op;
      logic [63:0] tw;
      e  = int'($urandom % NE);
      w  = int'($urandom % NW);
      op = int'($urandom % 3);
      t  = t + 64'($urandom % 700) + 64'd1;
      tw = (($urandom % 5) != 0) ? in_win(e, t) : t;
      case (op)
        0: do_write(e, w, $urandom, tw);
        1: do_commit(e, tw - 64'($urandom % 2000), tw);
        default: do_read(e, w, t, "R2");
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule